// File: doc/BRIEF.md
# PHY Register Access Handshake Port

This block gives a host CPU indirect access to a small bank of 8-bit PHY delay settings through a single 32-bit register on a simple register bus. The host packs a 6-bit PHY address, 8 bits of write data and a request bit into that register. A four-phase request/acknowledge handshake then carries out the transfer. Read results come back in a dedicated field of the same register. The block contains the bus decode, the access register, the handshake state machine and a model of the PHY register file.

A write goes like this. The host first stores the address and data with both request bits clear. It then stores the same value with the write request set and polls until the acknowledge bit reads 1. Finally it clears the request and waits for the acknowledge bit to fall. A read uses the read request bit in the same way, and the addressed setting appears in the read-data field by the time the acknowledge bit is seen high. The PHY side takes `ACC_LAT` cycles to complete each access.

Top module: `phy_acc_port`

## Requirements
- R1: After reset the access register reads 0 (acknowledge low), and every PHY register reads back as 0.
- R2: The access register sits at byte offset `ACC_OFFSET` (default 0x010). Its layout is: PHY address in [5:0], write data in [15:8], read data in [23:16], write request in bit 24, read request in bit 25 and acknowledge in bit 26. Bits [7:6] and [31:27] read as 0. Host writes to bits 16–23 and 26–31 have no effect. Any other offset reads as 0, and writes to it are dropped.
- R3: A write request raised while acknowledge is low stores the write data into the addressed PHY register. The acknowledge bit reads 1 starting at the `ACC_LAT+1`-th clock edge after the bus write that set the request (the 3rd with the default `ACC_LAT=2`).
- R4: A read request loads the addressed PHY register into [23:16] on the same edge that raises acknowledge. The field keeps that value until the next read completes.
- R5: Acknowledge stays high for as long as either request bit is set. It falls one clock edge after both request bits are seen clear.
- R6: While acknowledge is high, no new transfer starts. A changed address, changed data or a newly set request bit has no effect until acknowledge has fallen.
- R7: Only PHY addresses 0x00–0x08 and 0x0B–0x0D are implemented (mask `IMPL_MASK`). A write to any other address completes its handshake but stores nothing, and a read from such an address returns 0.
- R8: When both request bits are set together, the write is performed and no read takes place, so the read-data field keeps its previous value.
- R9: The address, the data and the transfer direction are captured on the first clock edge after the request is seen. Changing these fields while the transfer is in flight does not alter what is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register bus select |
| bus_we_i | input | 1 | Register bus write enable |
| bus_addr_i | input | BUS_AW | Register bus byte address |
| bus_wdata_i | input | 32 | Register bus write data |
| bus_rdata_o | output | 32 | Register bus read data (same cycle) |

## Verification
Writes of distinct values to the lowest, highest and middle implemented addresses, each followed by a read of the same address, show whether addresses alias and whether data bits get swapped. Patterns that break the protocol give the most information about the handshake. These are: fields changed while a transfer is in flight, which tells capture at the request apart from a live field; a new request while acknowledge is high, which tells a four-phase handshake apart from a level-triggered one; and both request bits set at once, which exposes the direction priority. Accesses to unimplemented PHY addresses and to a foreign bus offset separate the implemented bank from ghost storage. The exact cycle at which acknowledge rises and falls is checked once, against the latency parameter.

// File: rtl/phy_acc_pkg.sv
package phy_acc_pkg;
  localparam int PHY_AW      = 6;
  localparam int PHY_DW      = 8;
  localparam int PHY_NUM     = 1 << PHY_AW;
  localparam int F_ADDR_LSB  = 0;
  localparam int F_WDATA_LSB = 8;
  localparam int F_RDATA_LSB = 16;
  localparam int B_WR        = 24;
  localparam int B_RD        = 25;
  localparam int B_ACK       = 26;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } acc_state_e;
endpackage

// File: rtl/phy_acc_regif.sv
module phy_acc_regif
  import phy_acc_pkg::*;
#(
  parameter int          BUS_AW     = 10,
  parameter int unsigned ACC_OFFSET = 'h10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              ack_i,
  input  logic              rd_load_i,
  input  logic [PHY_DW-1:0] rd_value_i,
  output logic [PHY_AW-1:0] addr_o,
  output logic [PHY_DW-1:0] wdata_o,
  output logic              wr_req_o,
  output logic              rd_req_o
);
  logic              hit;
  logic [PHY_AW-1:0] addr_q;
  logic [PHY_DW-1:0] wdata_q, rdata_q;
  logic              wr_q, rd_q;

  assign hit = bus_sel_i && (bus_addr_i == BUS_AW'(ACC_OFFSET));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
    end else if (hit && bus_we_i) begin
      addr_q  <= bus_wdata_i[F_ADDR_LSB +: PHY_AW];
      wdata_q <= bus_wdata_i[F_WDATA_LSB +: PHY_DW];
      wr_q    <= bus_wdata_i[B_WR];
      rd_q    <= bus_wdata_i[B_RD];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_q <= '0;
    else if (rd_load_i) rdata_q <= rd_value_i;
  end

  always_comb begin
    bus_rdata_o = '0;
    if (hit) begin
      bus_rdata_o[F_ADDR_LSB +: PHY_AW]  = addr_q;
      bus_rdata_o[F_WDATA_LSB +: PHY_DW] = wdata_q;
      bus_rdata_o[F_RDATA_LSB +: PHY_DW] = rdata_q;
      bus_rdata_o[B_WR]                  = wr_q;
      bus_rdata_o[B_RD]                  = rd_q;
      bus_rdata_o[B_ACK]                 = ack_i;
    end
  end

  assign addr_o   = addr_q;
  assign wdata_o  = wdata_q;
  assign wr_req_o = wr_q;
  assign rd_req_o = rd_q;

  assert_rdata_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_load_i |=> $stable(rdata_q));
endmodule

// File: rtl/phy_acc_fsm.sv
module phy_acc_fsm
  import phy_acc_pkg::*;
#(
  parameter int ACC_LAT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_req_i,
  input  logic              rd_req_i,
  input  logic [PHY_AW-1:0] addr_i,
  input  logic [PHY_DW-1:0] wdata_i,
  output logic              ack_o,
  output logic              phy_we_o,
  output logic              rd_load_o,
  output logic [PHY_AW-1:0] op_addr_o,
  output logic [PHY_DW-1:0] op_data_o
);
  localparam int CNT_W = $clog2(ACC_LAT + 1);

  acc_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PHY_AW-1:0] snap_addr_q;
  logic [PHY_DW-1:0] snap_data_q;
  logic              snap_wr_q;
  logic              any_req, finish;

  assign any_req = wr_req_i || rd_req_i;
  assign finish  = (state_q == ST_BUSY) && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      snap_addr_q <= '0;
      snap_data_q <= '0;
      snap_wr_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (any_req) begin
          state_q     <= ST_BUSY;
          cnt_q       <= CNT_W'(ACC_LAT - 1);
          snap_addr_q <= addr_i;
          snap_data_q <= wdata_i;
          snap_wr_q   <= wr_req_i;  // write wins over read
        end
        ST_BUSY: begin
          if (cnt_q == '0) state_q <= ST_DONE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_DONE: if (!any_req) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ack_o     = (state_q == ST_DONE);
  assign phy_we_o  = finish && snap_wr_q;
  assign rd_load_o = finish && !snap_wr_q;
  assign op_addr_o = snap_addr_q;
  assign op_data_o = snap_data_q;

  assert_ack_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && any_req) |=> ack_o);
  assert_ack_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && !any_req) |=> !ack_o);
endmodule

// File: rtl/phy_acc_regfile.sv
module phy_acc_regfile
  import phy_acc_pkg::*;
#(
  parameter logic [PHY_NUM-1:0] IMPL_MASK = 64'h0000_0000_0000_39FF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PHY_AW-1:0] addr_i,
  input  logic [PHY_DW-1:0] wdata_i,
  output logic [PHY_DW-1:0] rdata_o
);
  logic [PHY_DW-1:0] regs_q [PHY_NUM];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PHY_NUM; i++) regs_q[i] <= '0;
    end else if (we_i && IMPL_MASK[addr_i]) begin
      regs_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = IMPL_MASK[addr_i] ? regs_q[addr_i] : '0;
endmodule

// File: rtl/phy_acc_port.sv
module phy_acc_port
  import phy_acc_pkg::*;
#(
  parameter int                 BUS_AW     = 10,
  parameter int unsigned        ACC_OFFSET = 'h10,
  parameter int                 ACC_LAT    = 2,
  parameter logic [PHY_NUM-1:0] IMPL_MASK  = 64'h0000_0000_0000_39FF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o
);
  logic              ack, phy_we, rd_load, wr_req, rd_req;
  logic [PHY_AW-1:0] fld_addr, op_addr;
  logic [PHY_DW-1:0] fld_wdata, op_data, rf_rdata;

  phy_acc_regif #(.BUS_AW(BUS_AW), .ACC_OFFSET(ACC_OFFSET)) u_regif (
    .clk_i, .rst_ni, .bus_sel_i, .bus_we_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
    .ack_i(ack), .rd_load_i(rd_load), .rd_value_i(rf_rdata),
    .addr_o(fld_addr), .wdata_o(fld_wdata), .wr_req_o(wr_req), .rd_req_o(rd_req)
  );

  phy_acc_fsm #(.ACC_LAT(ACC_LAT)) u_fsm (
    .clk_i, .rst_ni, .wr_req_i(wr_req), .rd_req_i(rd_req),
    .addr_i(fld_addr), .wdata_i(fld_wdata), .ack_o(ack),
    .phy_we_o(phy_we), .rd_load_o(rd_load), .op_addr_o(op_addr), .op_data_o(op_data)
  );

  phy_acc_regfile #(.IMPL_MASK(IMPL_MASK)) u_rf (
    .clk_i, .rst_ni, .we_i(phy_we), .addr_i(op_addr), .wdata_i(op_data), .rdata_o(rf_rdata)
  );

  assert_commit_then_ack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_we |=> ack);
  assert_no_access_acked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack |-> !(phy_we || rd_load));
endmodule

// File: tb/phy_acc_port_tb_top.sv
module phy_acc_port_tb_top;
  localparam int AW  = 10;
  localparam int LAT = 2;
  localparam logic [AW-1:0] ACC = 10'h010;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  phy_acc_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata)
  );

  function automatic logic [31:0] mk(input logic [5:0] a, input logic [7:0] d,
                                     input logic w, input logic r);
    return {6'b0, r, w, 8'h00, d, 2'b00, a};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr_bus(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd_bus(input logic [AW-1:0] a, output logic [31:0] d);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic poll_ack(input string req, input logic exp);
    logic [31:0] v;
    for (int i = 0; i < 40; i++) begin
      rd_bus(ACC, v);
      if (v[26] == exp) return;
      @(negedge clk);
    end
    check(req, {31'b0, ~exp}, {31'b0, exp});
  endtask

  task automatic phy_write(input logic [5:0] a, input logic [7:0] d);
    wr_bus(ACC, mk(a, d, 1'b0, 1'b0));
    wr_bus(ACC, mk(a, d, 1'b1, 1'b0));
    poll_ack("R3 write ack", 1'b1);
    wr_bus(ACC, mk(a, d, 1'b0, 1'b0));
    poll_ack("R5 write release", 1'b0);
  endtask

  task automatic phy_read(input logic [5:0] a, output logic [7:0] d);
    logic [31:0] v;
    wr_bus(ACC, mk(a, 8'h00, 1'b0, 1'b1));
    poll_ack("R4 read ack", 1'b1);
    rd_bus(ACC, v);
    d = v[23:16];
    wr_bus(ACC, mk(a, 8'h00, 1'b0, 1'b0));
    poll_ack("R5 read release", 1'b0);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    logic [7:0] d;
    rd_bus(ACC, v);
    check("R1 access reg at reset", v, 32'h0);
    phy_read(6'h00, d);
    check("R1 phy 0x00 at reset", {24'b0, d}, 32'h0);
    phy_read(6'h0D, d);
    check("R1 phy 0x0D at reset", {24'b0, d}, 32'h0);
  endtask

  task automatic t_decode;
    logic [31:0] v;
    wr_bus(ACC, 32'hFC00_FFFF);
    rd_bus(ACC, v);
    check("R2 field layout", v, 32'h0000_FF3F);
    wr_bus(ACC + 10'h4, 32'h0100_1234);
    rd_bus(ACC + 10'h4, v);
    check("R2 foreign offset reads 0", v, 32'h0);
    repeat (4) @(negedge clk);
    rd_bus(ACC, v);
    check("R2 foreign write dropped, no transfer", v, 32'h0000_FF3F);
    wr_bus(ACC, 32'h0);
  endtask

  task automatic t_patterns;
    logic [7:0] d;
    phy_write(6'h00, 8'hA5);
    phy_write(6'h08, 8'h5A);
    phy_write(6'h0B, 8'h01);
    phy_write(6'h0C, 8'h80);
    phy_write(6'h0D, 8'hFF);
    phy_read(6'h00, d); check("R3 R4 phy 0x00", {24'b0, d}, 32'hA5);
    phy_read(6'h08, d); check("R3 R4 phy 0x08", {24'b0, d}, 32'h5A);
    phy_read(6'h0B, d); check("R3 R4 phy 0x0B", {24'b0, d}, 32'h01);
    phy_read(6'h0C, d); check("R3 R4 phy 0x0C", {24'b0, d}, 32'h80);
    phy_read(6'h0D, d); check("R3 R4 phy 0x0D", {24'b0, d}, 32'hFF);
  endtask

  task automatic t_timing;
    logic [31:0] v;
    logic [7:0] d;
    wr_bus(ACC, mk(6'h03, 8'h33, 1'b0, 1'b0));
    wr_bus(ACC, mk(6'h03, 8'h33, 1'b1, 1'b0));
    for (int k = 0; k <= LAT + 1; k++) begin
      if (k > 0) @(negedge clk);
      rd_bus(ACC, v);
      check("R3 ack latency", {31'b0, v[26]}, {31'b0, (k == LAT + 1)});
    end
    wr_bus(ACC, mk(6'h03, 8'h33, 1'b0, 1'b0));
    rd_bus(ACC, v);
    check("R5 ack still high at clear", {31'b0, v[26]}, 32'h1);
    @(negedge clk);
    rd_bus(ACC, v);
    check("R5 ack falls one edge later", {31'b0, v[26]}, 32'h0);
    phy_read(6'h03, d);
    check("R3 phy 0x03", {24'b0, d}, 32'h33);
  endtask

  task automatic t_ignore_acked;
    logic [31:0] v;
    logic [7:0] d;
    phy_read(6'h00, d);
    wr_bus(ACC, mk(6'h04, 8'h44, 1'b1, 1'b0));
    poll_ack("R6 ack", 1'b1);
    wr_bus(ACC, mk(6'h04, 8'h99, 1'b1, 1'b0));
    repeat (4) @(negedge clk);
    wr_bus(ACC, mk(6'h08, 8'h00, 1'b0, 1'b1));
    repeat (4) @(negedge clk);
    rd_bus(ACC, v);
    check("R6 no read while acked", {24'b0, v[23:16]}, 32'hA5);
    check("R6 ack held", {31'b0, v[26]}, 32'h1);
    wr_bus(ACC, 32'h0);
    poll_ack("R6 release", 1'b0);
    phy_read(6'h04, d);
    check("R6 no rewrite while acked", {24'b0, d}, 32'h44);
  endtask

  task automatic t_snapshot;
    logic [7:0] d;
    wr_bus(ACC, mk(6'h05, 8'h55, 1'b1, 1'b0));
    wr_bus(ACC, mk(6'h06, 8'h77, 1'b1, 1'b0));
    poll_ack("R9 ack", 1'b1);
    wr_bus(ACC, 32'h0);
    poll_ack("R9 release", 1'b0);
    phy_read(6'h05, d);
    check("R9 captured data", {24'b0, d}, 32'h55);
    phy_read(6'h06, d);
    check("R9 late fields unused", {24'b0, d}, 32'h0);
  endtask

  task automatic t_unimpl;
    logic [7:0] d;
    phy_write(6'h09, 8'h12);
    phy_write(6'h0A, 8'h23);
    phy_write(6'h0E, 8'h34);
    phy_write(6'h3F, 8'h45);
    phy_read(6'h09, d); check("R7 phy 0x09", {24'b0, d}, 32'h0);
    phy_read(6'h0A, d); check("R7 phy 0x0A", {24'b0, d}, 32'h0);
    phy_read(6'h0E, d); check("R7 phy 0x0E", {24'b0, d}, 32'h0);
    phy_read(6'h3F, d); check("R7 phy 0x3F", {24'b0, d}, 32'h0);
    phy_read(6'h08, d); check("R7 neighbour intact", {24'b0, d}, 32'h5A);
  endtask

  task automatic t_both;
    logic [31:0] v;
    logic [7:0] d;
    phy_read(6'h00, d);
    wr_bus(ACC, mk(6'h0B, 8'h6C, 1'b1, 1'b1));
    poll_ack("R8 ack", 1'b1);
    rd_bus(ACC, v);
    check("R8 no read when both set", {24'b0, v[23:16]}, 32'hA5);
    wr_bus(ACC, 32'h0);
    poll_ack("R8 release", 1'b0);
    phy_read(6'h0B, d);
    check("R8 write performed", {24'b0, d}, 32'h6C);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_decode();
    t_patterns();
    t_timing();
    t_ignore_acked();
    t_snapshot();
    t_unimpl();
    t_both();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R3 watchdog: actual=hung expected=completed");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule